// File: doc/BRIEF.md
# Per-Core Mailbox Interrupt Aggregator

This block holds the interrupt state of one receiving core in a mailbox subsystem that has a set of message channels. Every channel can raise two kinds of event toward the core: a request event, when a sender asks the core to service the channel, and a done event, when the channel's transaction has completed. The block latches these single-cycle events into a sticky flag register. A mask register decides which events may set flags. An enable register decides which flags reach the core's interrupt line. A status view returns the flags that are both set and enabled.

Software in the core reaches the block through a simple synchronous register port. Reads return data one cycle after the address is presented. The mask, enable and flag registers each have their own lock bit in a control register. Software clears the lock, writes the register, and sets the lock again. A write that arrives while the lock is set has no effect. Flags are cleared by writing ones to them. The chip places one copy of this block for each core that receives mailbox interrupts, for example the application core and the security core.

Top module: `mbox_irq_agg`

## Requirements
- R1: After reset the control register reads 3'b111 (every lock set), and the mask, enable and flag registers read zero. `irq` is low.
- R2: The control register at address 0 accepts every write. Bit 0 locks the mask register, bit 1 locks the enable register and bit 2 locks the flag register. A lock bit of 1 means locked.
- R3: The mask register at address 1 takes the written value only when control bit 0 is clear at the write edge. Otherwise the write is ignored.
- R4: With 16 channels, a request event on channel n maps to flag bit n and a done event on channel n maps to flag bit n+16. An event sets its flag only when the matching mask bit is 1. A set flag stays set until software clears it, even if the mask bit is later cleared.
- R5: The enable register at address 2 takes the written value only when control bit 1 is clear at the write edge. Otherwise the write is ignored.
- R6: A write to the flag register at address 3 clears each flag whose data bit is 1 and leaves the other flags unchanged. It does this only when control bit 2 is clear. When control bit 2 is set, the write is ignored.
- R7: If an accepted event and a clear-by-write-of-one hit the same flag bit in the same cycle, the flag is set afterwards.
- R8: Address 4 reads the flags ANDed with the enables. Writes to address 4 change nothing.
- R9: `rd_data` is registered. After a clock edge it shows the register selected by `rd_addr` as that register stood before the edge. Addresses 5 to 7 read zero.
- R10: `irq` is registered. After each edge it equals the OR of all flag-and-enable bits as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Registered read data |
| req_evt | input | 16 | Per-channel request event pulses |
| done_evt | input | 16 | Per-channel done event pulses |
| irq | output | 1 | Registered interrupt line to the core |

## Verification
The bench builds the block with its default of 16 channels. At that size the flag word is a full 32 bits, and the boundary between the request half and the done half falls at bits 15 and 16. Directed cases hit that boundary, along with a clear that coincides with an event and with writes made while each lock is set. Random traffic draws addresses across all eight codes, including the unused ones. It toggles the locks through random control writes and fires sparse event bursts. A cycle model of the registers predicts both `rd_data` and `irq` on every cycle.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int          ADDR_W    = 3;
  localparam int          NUM_LOCKS = 3;
  localparam int          LK_MASK   = 0;
  localparam int          LK_EN     = 1;
  localparam int          LK_FLAG   = 2;
  localparam logic [2:0]  A_CTRL    = 3'd0;
  localparam logic [2:0]  A_MASK    = 3'd1;
  localparam logic [2:0]  A_EN      = 3'd2;
  localparam logic [2:0]  A_FLAG    = 3'd3;
  localparam logic [2:0]  A_STAT    = 3'd4;
endpackage

// File: rtl/mbox_lock_ctrl.sv
module mbox_lock_ctrl
  import mbox_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_sel,
  input  logic [NUM_LOCKS-1:0] wr_data,
  output logic [NUM_LOCKS-1:0] lock_q
);
  always_ff @(posedge clk) begin
    if (rst)         lock_q <= '1;
    else if (wr_sel) lock_q <= wr_data;
  end
endmodule

// File: rtl/mbox_guarded_reg.sv
module mbox_guarded_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_sel,
  input  logic         locked,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                   q <= '0;
    else if (wr_sel && !locked) q <= wr_data;
  end
endmodule

// File: rtl/mbox_evt_flags.sv
module mbox_evt_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic         clr_sel,
  input  logic         locked,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] flags_q
);
  logic clr_ok;
  assign clr_ok = clr_sel && !locked;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        flags_q[i] <= 1'b0;
      else if (evt[i] && mask[i])     flags_q[i] <= 1'b1;
      else if (clr_ok && clr_data[i]) flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_irq_out.sv
module mbox_irq_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  output logic [W-1:0] status,
  output logic         irq
);
  assign status = flags & en;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |status;
  end
endmodule

// File: rtl/mbox_irq_agg.sv
module mbox_irq_agg
  import mbox_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int DW    = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NUM_CH-1:0] req_evt,
  input  logic [NUM_CH-1:0] done_evt,
  output logic              irq
);
  logic [NUM_LOCKS-1:0] lock_q;
  logic [DW-1:0]        mask_q;
  logic [DW-1:0]        en_q;
  logic [DW-1:0]        flags_q;
  logic [DW-1:0]        status;
  logic [DW-1:0]        evt_vec;
  logic                 sel_ctrl, sel_mask, sel_en, sel_flag;

  assign evt_vec  = {done_evt, req_evt};
  assign sel_ctrl = wr_en && (wr_addr == A_CTRL);
  assign sel_mask = wr_en && (wr_addr == A_MASK);
  assign sel_en   = wr_en && (wr_addr == A_EN);
  assign sel_flag = wr_en && (wr_addr == A_FLAG);

  mbox_lock_ctrl u_lock (
    .clk(clk), .rst(rst), .wr_sel(sel_ctrl),
    .wr_data(wr_data[NUM_LOCKS-1:0]), .lock_q(lock_q)
  );

  mbox_guarded_reg #(.W(DW)) u_mask (
    .clk(clk), .rst(rst), .wr_sel(sel_mask), .locked(lock_q[LK_MASK]),
    .wr_data(wr_data), .q(mask_q)
  );

  mbox_guarded_reg #(.W(DW)) u_en (
    .clk(clk), .rst(rst), .wr_sel(sel_en), .locked(lock_q[LK_EN]),
    .wr_data(wr_data), .q(en_q)
  );

  mbox_evt_flags #(.W(DW)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_vec), .mask(mask_q),
    .clr_sel(sel_flag), .locked(lock_q[LK_FLAG]),
    .clr_data(wr_data), .flags_q(flags_q)
  );

  mbox_irq_out #(.W(DW)) u_irq (
    .clk(clk), .rst(rst), .flags(flags_q), .en(en_q),
    .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= {{(DW-NUM_LOCKS){1'b0}}, lock_q};
        A_MASK:  rd_data <= mask_q;
        A_EN:    rd_data <= en_q;
        A_FLAG:  rd_data <= flags_q;
        A_STAT:  rd_data <= status;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_irq_agg_chk.sv
module mbox_irq_agg_chk #(
  parameter int NUM_CH = 16,
  localparam int DW    = 2 * NUM_CH
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic [2:0]    lock_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] en_q,
  input logic [DW-1:0] flags_q,
  input logic [DW-1:0] evt_vec
);
  // R1
  reset_irq_low_chk: assert property (@(posedge clk) rst |=> !irq);

  // R3
  mask_lock_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q[0] |=> $stable(mask_q));

  // R5
  en_lock_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q[1] |=> $stable(en_q));

  // R6
  flag_lock_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q[2] |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R4
  masked_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((flags_q & ~$past(flags_q) & ~$past(evt_vec & mask_q)) == '0));

  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt_vec & mask_q) != '0) |=>
      ((flags_q & $past(evt_vec & mask_q)) == $past(evt_vec & mask_q)));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(flags_q & en_q))));
endmodule

bind mbox_irq_agg mbox_irq_agg_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .lock_q(lock_q), .mask_q(mask_q),
  .en_q(en_q), .flags_q(flags_q), .evt_vec(evt_vec)
);

// File: tb/mbox_irq_agg_tb.sv
module mbox_irq_agg_tb;
  localparam int NCH = 16;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NCH-1:0] req_evt = '0;
  logic [NCH-1:0] done_evt = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [2:0]    m_lk = 3'b111;
  logic [DW-1:0] m_mask = '0, m_en = '0, m_flags = '0;

  always #2.5 clk = ~clk;

  mbox_irq_agg #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_evt(req_evt),
    .done_evt(done_evt), .irq(irq)
  );

  function automatic logic [DW-1:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'b0, m_lk};
      3'd1: return m_mask;
      3'd2: return m_en;
      3'd3: return m_flags;
      3'd4: return m_flags & m_en;
      default: return '0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives inputs, models the edge, checks at the next negedge.
  task automatic cycle(input string tag, input logic we, input logic [2:0] wa,
                       input logic [DW-1:0] wd, input logic [2:0] ra,
                       input logic [NCH-1:0] rq, input logic [NCH-1:0] dn);
    logic [DW-1:0] exp_rd, evt, clr, nm, ne, nf;
    logic [2:0]    nl;
    logic          exp_irq;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    req_evt = rq; done_evt = dn;
    @(posedge clk);
    exp_rd  = model_read(ra);
    exp_irq = |(m_flags & m_en);
    evt = {dn, rq};
    nl  = (we && wa == 3'd0) ? wd[2:0] : m_lk;
    nm  = (we && wa == 3'd1 && !m_lk[0]) ? wd : m_mask;
    ne  = (we && wa == 3'd2 && !m_lk[1]) ? wd : m_en;
    clr = (we && wa == 3'd3 && !m_lk[2]) ? wd : '0;
    nf  = (m_flags & ~clr) | (evt & m_mask);
    m_lk = nl; m_mask = nm; m_en = ne; m_flags = nf;
    @(negedge clk);
    check((tag == "") ? addr_tag(ra) : tag, rd_data, exp_rd);
    check("R10", {31'b0, irq}, {31'b0, exp_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {31'b0, irq}, 32'd0);
    rst = 1'b0;
    // R1: reset values through the read port
    cycle("R1", 0, 0, 0, 3'd0, 0, 0);
    cycle("R1", 0, 0, 0, 3'd1, 0, 0);
    cycle("R1", 0, 0, 0, 3'd2, 0, 0);
    cycle("R1", 0, 0, 0, 3'd3, 0, 0);
    // R3: mask write while locked is ignored
    cycle("R3", 1, 3'd1, '1, 3'd1, 0, 0);
    cycle("R3", 0, 0, 0, 3'd1, 0, 0);
    // R4: masked-off event sets nothing
    cycle("R4", 0, 0, 0, 3'd3, 16'h8000, 16'h0001);
    cycle("R4", 0, 0, 0, 3'd3, 0, 0);
    // R2: unlock all
    cycle("R2", 1, 3'd0, 32'h0, 3'd0, 0, 0);
    cycle("R2", 0, 0, 0, 3'd0, 0, 0);
    cycle("R3", 1, 3'd1, '1, 3'd1, 0, 0);
    cycle("R5", 1, 3'd2, 32'h0001_0000, 3'd2, 0, 0);
    // R4: boundary bits 15 (request ch15) and 16 (done ch0)
    cycle("R4", 0, 0, 0, 3'd3, 16'h8000, 16'h0001);
    cycle("R4", 0, 0, 0, 3'd3, 0, 0);
    cycle("R8", 0, 0, 0, 3'd4, 0, 0);
    // R7: clear and event on bit 15 together
    cycle("R7", 1, 3'd3, 32'h0000_8000, 3'd3, 16'h8000, 0);
    cycle("R7", 0, 0, 0, 3'd3, 0, 0);
    // R6: clear bit 16 only
    cycle("R6", 1, 3'd3, 32'h0001_0000, 3'd3, 0, 0);
    cycle("R6", 0, 0, 0, 3'd3, 0, 0);
    // R6: lock flags, clear-all ignored
    cycle("R2", 1, 3'd0, 32'h4, 3'd0, 0, 0);
    cycle("R6", 1, 3'd3, '1, 3'd3, 0, 0);
    cycle("R6", 0, 0, 0, 3'd3, 0, 0);
    // R8: status is read-only
    cycle("R8", 1, 3'd4, '1, 3'd4, 0, 0);
    cycle("R9", 0, 0, 0, 3'd6, 0, 0);
    // R5: enable locked
    cycle("R2", 1, 3'd0, 32'h2, 3'd0, 0, 0);
    cycle("R5", 1, 3'd2, '1, 3'd2, 0, 0);
    cycle("R5", 0, 0, 0, 3'd2, 0, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]    wa;
      logic [DW-1:0] wd;
      wa = 3'($urandom_range(0, 7));
      wd = $urandom;
      if (wa == 3'd3) wd = wd & $urandom;
      cycle("", ($urandom_range(0, 3) == 0), wa, wd, 3'($urandom_range(0, 7)),
            16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule